// File: doc/BRIEF.md
# Converter Serial Port Emulator

This block is a bus-functional stand-in for the digital side of a 12-bit sampling converter. A single frame strobe controls both phases of the exchange. When the strobe rises, a conversion starts: the block latches a 12-bit code from a parallel input bus and holds a busy status for a fixed number of system-clock cycles. When the strobe is low, the block drives the captured code out serially, most significant bit first, and shifts in a short channel-configuration word on the same serial clock.

The strobe and the serial clock are treated as slow signals. Their edges are detected in the system clock domain. Output bits advance on falling serial-clock edges, and input bits are taken on rising edges. After the last code bit, the output sends zeros for as long as the serial clock keeps running with the strobe low. The 2-bit configuration word captured during a readout does not affect that readout. It is reported, on `cfgApplied`, for the conversion that the next strobe rise starts.

Top module: `conv_port_emu`

## Requirements
- R1: After reset with the strobe held high, `busyOut`, `sleepOut`, `sdoEn`, `sdoOut` and `cfgApplied` are all 0.
- R2: A strobe rising edge, seen at the next clock edge, starts a conversion. That edge latches `resultIn`, and `busyOut` stays high for exactly CONV_CYCLES clock cycles.
- R3: If the strobe is high when the conversion ends, `sleepOut` goes high and stays high until the strobe falls.
- R4: `sdoEn` is 0 one clock after the strobe goes high and 1 one clock after it goes low. `sdoOut` is 0 whenever `sdoEn` is 0.
- R5: The latched code leaves most significant bit first. Bit 11 is on `sdoOut` as soon as `sdoEn` rises. Each falling serial-clock edge moves to the next lower bit.
- R6: After bit 0 has been sent, every further falling serial-clock edge with the strobe low gives `sdoOut` = 0.
- R7: The first two rising serial-clock edges of a readout capture `sdiIn`, first bit into bit 1 of the configuration word. Later rising edges in the same readout change nothing.
- R8: `cfgApplied` changes only when a conversion starts. It then takes the last fully captured configuration word, which is 00 after reset.
- R9: Codes are passed unchanged as straight binary: 0x000 reads as twelve zeros and 0xFFF as twelve ones.
- R10: A strobe rising edge in the middle of a readout abandons it. A new conversion starts, with a fresh code latched.
- R11: If the strobe falls during a conversion, the block does not sleep. The readout starts when the conversion ends, starting at bit 11. Serial-clock edges during the conversion neither shift data nor capture configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameIn | input | 1 | Conversion-start and readout frame strobe |
| sclkIn | input | 1 | Serial clock |
| sdiIn | input | 1 | Serial configuration data in |
| resultIn | input | 12 | Conversion code, latched at conversion start |
| sdoOut | output | 1 | Serial data out (0 while disabled) |
| sdoEn | output | 1 | Output drive enable (low means high impedance) |
| busyOut | output | 1 | Conversion in progress |
| sleepOut | output | 1 | Conversion ended with the strobe still high |
| cfgApplied | output | 2 | Configuration word that applies to the current conversion |

## Verification
The hardest case to reach is the set of ordering effects around the strobe. These are a strobe that falls before the conversion time has run out, serial clocks applied while the conversion is still busy, and a strobe that rises again partway through a readout. Directed sequences after the table walk reach each case. Each one places strobe and serial-clock edges at chosen cycle offsets from the conversion start. The checks then confirm the first bit read, whether sleep was entered, and which configuration word the following conversion reports.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SLEEP,
    ST_READ
  } portState_e;

  // Strobes from control to datapath, all one clock wide.
  typedef struct packed {
    logic load;      // latch code, apply pending configuration
    logic shiftOut;  // advance serial output by one bit
    logic capBit;    // shift one configuration bit in
    logic capLast;   // this capture completes the configuration word
  } dpCtl_t;

endpackage

// File: rtl/conv_port_ctrl.sv
module conv_port_ctrl
  import conv_port_pkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int CFG_W       = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameIn,
  input  logic   sclkIn,
  output dpCtl_t dpCtl,
  output logic   busy,
  output logic   sleep,
  output logic   drvEn
);

  localparam int CNT_W  = $clog2(CONV_CYCLES + 1);
  localparam int CFGC_W = $clog2(CFG_W + 1);

  portState_e        state;
  logic              framePrev, sclkPrev;
  logic [CNT_W-1:0]  convCnt;
  logic [CFGC_W-1:0] cfgCnt;

  logic frameRise, frameFall, sclkRise, sclkFall, convDone;

  assign frameRise = frameIn & ~framePrev;
  assign frameFall = ~frameIn & framePrev;
  assign sclkRise  = sclkIn & ~sclkPrev;
  assign sclkFall  = ~sclkIn & sclkPrev;
  assign convDone  = (state == ST_CONV) && (convCnt == CNT_W'(CONV_CYCLES - 1));

  always_comb begin
    dpCtl          = '0;
    dpCtl.load     = frameRise && (state != ST_CONV);
    dpCtl.shiftOut = (state == ST_READ) && sclkFall;
    dpCtl.capBit   = (state == ST_READ) && sclkRise && (cfgCnt < CFGC_W'(CFG_W));
    dpCtl.capLast  = dpCtl.capBit && (cfgCnt == CFGC_W'(CFG_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePrev <= 1'b1;
      sclkPrev  <= 1'b0;
      state     <= ST_IDLE;
      convCnt   <= '0;
      cfgCnt    <= '0;
    end else begin
      framePrev <= frameIn;
      sclkPrev  <= sclkIn;
      if (dpCtl.load) begin
        state   <= ST_CONV;
        convCnt <= '0;
        cfgCnt  <= '0;
      end else begin
        unique case (state)
          ST_CONV: begin
            if (convDone) state <= frameIn ? ST_SLEEP : ST_READ;
            else          convCnt <= convCnt + 1'b1;
          end
          ST_SLEEP, ST_IDLE: if (frameFall) state <= ST_READ;
          ST_READ:  if (dpCtl.capBit) cfgCnt <= cfgCnt + 1'b1;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy  = (state == ST_CONV);
  assign sleep = (state == ST_SLEEP);
  assign drvEn = ~framePrev;

endmodule

// File: rtl/conv_port_dp.sv
module conv_port_dp
  import conv_port_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              sdiIn,
  output logic              sdoBit,
  output logic [CFG_W-1:0]  cfgApplied
);

  logic [DATA_W-1:0] shiftReg;
  logic [CFG_W-1:0]  cfgTemp, cfgPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      cfgTemp    <= '0;
      cfgPending <= '0;
      cfgApplied <= '0;
    end else begin
      if (dpCtl.load)          shiftReg <= resultIn;
      else if (dpCtl.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      if (dpCtl.capBit)  cfgTemp    <= {cfgTemp[CFG_W-2:0], sdiIn};
      if (dpCtl.capLast) cfgPending <= {cfgTemp[CFG_W-2:0], sdiIn};
      if (dpCtl.load)    cfgApplied <= cfgPending;
    end
  end

  assign sdoBit = shiftReg[DATA_W-1];

endmodule

// File: rtl/conv_port_emu.sv
module conv_port_emu
  import conv_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CFG_W       = 2,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic              busyOut,
  output logic              sleepOut,
  output logic [CFG_W-1:0]  cfgApplied
);

  dpCtl_t dpCtl;
  logic   sdoBit;

  conv_port_ctrl #(.CONV_CYCLES(CONV_CYCLES), .CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameIn (frameIn),
    .sclkIn  (sclkIn),
    .dpCtl   (dpCtl),
    .busy    (busyOut),
    .sleep   (sleepOut),
    .drvEn   (sdoEn)
  );

  conv_port_dp #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .resultIn   (resultIn),
    .sdiIn      (sdiIn),
    .sdoBit     (sdoBit),
    .cfgApplied (cfgApplied)
  );

  assign sdoOut = sdoEn & sdoBit;

endmodule

// File: rtl/conv_port_emu_chk.sv
module conv_port_emu_chk #(
  parameter int CFG_W       = 2,
  parameter int CONV_CYCLES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameIn,
  input logic             sdoOut,
  input logic             sdoEn,
  input logic             busyOut,
  input logic             sleepOut,
  input logic [CFG_W-1:0] cfgApplied
);

  localparam int RUN_W = $clog2(CONV_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)        busyRun <= '0;
    else if (busyOut) busyRun <= busyRun + 1'b1;
    else              busyRun <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> (busyRun < RUN_W'(CONV_CYCLES)));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> $past(frameIn));

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> (sleepOut == $past(frameIn)));

  // R4
  hiz_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameIn) |-> !sdoEn);

  // R4
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdoOut);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(busyOut) |-> $stable(cfgApplied));

  // R3
  state_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOut && sleepOut));

endmodule

bind conv_port_emu conv_port_emu_chk #(.CFG_W(CFG_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (.*);

// File: tb/conv_port_emu_bench.sv
`timescale 1ns/1ps
module conv_port_emu_bench;

  localparam int CONV = 16;

  // {code[11:0], cfg[1:0]}
  localparam logic [13:0] VEC [4] = '{
    {12'hA5C, 2'b10},
    {12'h000, 2'b01},
    {12'hFFF, 2'b11},
    {12'h3C1, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameIn = 1'b1;
  logic        sclkIn = 1'b0;
  logic        sdiIn = 1'b0;
  logic [11:0] resultIn = '0;
  logic        sdoOut, sdoEn, busyOut, sleepOut;
  logic [1:0]  cfgApplied;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  conv_port_emu #(.CONV_CYCLES(CONV)) u_conv_port_emu (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .resultIn(resultIn), .sdoOut(sdoOut), .sdoEn(sdoEn), .busyOut(busyOut),
    .sleepOut(sleepOut), .cfgApplied(cfgApplied)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    sdiIn = d;
    sclkIn = 1'b1;
    tick(2);
    sclkIn = 1'b0;
    tick(2);
  endtask

  initial begin
    logic [1:0]  expPend;
    logic [11:0] code;
    logic [1:0]  cfg;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 busy", 32'(busyOut), 0);
    chk("R1 sleep", 32'(sleepOut), 0);
    chk("R1 sdoEn", 32'(sdoEn), 0);
    chk("R1 sdo", 32'(sdoOut), 0);
    chk("R1 cfg", 32'(cfgApplied), 0);

    expPend = 2'b00;
    frameIn = 1'b0;
    tick(2);
    for (int i = 0; i < 4; i++) begin
      code = VEC[i][13:2];
      cfg  = VEC[i][1:0];
      frameIn  = 1'b1;
      resultIn = code;
      tick(2);
      chk("R8 cfg applied at start", 32'(cfgApplied), 32'(expPend));
      chk("R4 hi-z while strobe high", 32'(sdoEn), 0);
      resultIn = ~code;
      tick(CONV - 2);
      chk("R2 busy last cycle", 32'(busyOut), 1);
      tick(1);
      chk("R2 busy ended", 32'(busyOut), 0);
      chk("R3 sleep", 32'(sleepOut), 1);
      frameIn = 1'b0;
      tick(2);
      chk("R3 sleep left", 32'(sleepOut), 0);
      chk("R4 driven while low", 32'(sdoEn), 1);
      chk("R5 R9 bit11 first", 32'(sdoOut), 32'(code[11]));
      for (int k = 0; k < 14; k++) begin
        pulse((k < 2) ? cfg[1-k] : ~cfg[k % 2]);
        if (k + 1 < 12) chk("R5 R9 serial bit", 32'(sdoOut), 32'(code[10-k]));
        else            chk("R6 trailing zero", 32'(sdoOut), 0);
      end
      expPend = cfg;  // R7: only the first two bits count
    end

    // R10: abandon a readout
    frameIn = 1'b1;
    resultIn = 12'h5A6;
    tick(CONV + 3);
    frameIn = 1'b0;
    tick(2);
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b0);
    frameIn = 1'b1;
    resultIn = 12'h9E7;
    tick(2);
    chk("R10 busy after mid-read rise", 32'(busyOut), 1);
    chk("R10 output released", 32'(sdoEn), 0);
    chk("R8 cfg from abandoned frame", 32'(cfgApplied), 32'h3);
    tick(CONV);
    frameIn = 1'b0;
    tick(2);
    chk("R10 new code bit11", 32'(sdoOut), 1);
    pulse(1'b0);
    chk("R10 new code bit10", 32'(sdoOut), 0);
    pulse(1'b0);
    pulse(1'b0);
    chk("R10 new code bit8", 32'(sdoOut), 1);

    // R11: strobe falls during conversion, clocks during busy ignored
    frameIn = 1'b1;
    resultIn = 12'hC35;
    tick(2);
    frameIn = 1'b0;
    tick(2);
    pulse(1'b1);
    pulse(1'b0);
    tick(CONV);
    chk("R11 no sleep", 32'(sleepOut), 0);
    chk("R11 conversion over", 32'(busyOut), 0);
    chk("R11 bit11 not shifted", 32'(sdoOut), 1);
    pulse(1'b0);
    chk("R11 bit10", 32'(sdoOut), 1);
    pulse(1'b0);
    chk("R11 bit9", 32'(sdoOut), 0);
    frameIn = 1'b1;
    tick(2);
    chk("R11 R7 busy-time bits not captured", 32'(cfgApplied), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule